// File: doc/BRIEF.md
# GPIO Interrupt Bank Controller

This block turns changes on a bank of up to 32 general-purpose input pins into one interrupt request. Each pin first passes through a two-flop synchroniser. It is then sampled at a debounced rate. The block compares each new sample with the one before it, under a trigger condition chosen for that pin. A pin that meets its condition sets a sticky pending bit in a status register. The bank interrupt line is the OR of the pending bits whose enable bits are set.

Software uses a plain register port with single-cycle writes and combinational reads. It has no handshake and no back-pressure: a write takes effect at the clock edge where `reg_we` is high. Through this port software sets a 4-bit trigger field per pin, sets an enable mask, acknowledges pending bits by writing ones, and sets the debounce control. The debounce clock is taken from one of two tick inputs, a slow one and a fast one, each a single-cycle enable pulse in the `clk` domain. The selected ticks are divided by 2^n.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0 and `irq_out` is low. A zero field means rising-edge mode, enables are off, nothing is pending, and the debounce clock is the slow tick with no division.
- R2: The trigger field of pin i is bits [4*(i%8)+3 : 4*(i%8)] of configuration word i/8, at addresses 0 to 3. The codes are 0 = rising edge, 1 = falling edge, 2 = level high, 3 = level low and 4 = both edges. Codes 5 to 15 never trigger. Configuration words read back exactly as written.
- R3: An edge-mode pin sets its pending bit when two consecutive samples differ in the selected direction. Rising means 0 then 1, falling means 1 then 0, and both-edges means either.
- R4: A level-mode pin sets its pending bit on every sample that shows the selected level. Clearing the bit while the level still holds lasts only until the next sample. Once a sample shows the level released, a clear stays in force.
- R5: Writing the status register (address 5) clears each bit written as 1 and leaves each bit written as 0. If a detection and a clear hit the same bit in the same cycle, the bit ends up set.
- R6: Pending bits are set whatever the enable mask (address 4) holds. `irq_out` is high exactly when some bit is both pending and enabled. Changing the enable mask changes only that gating.
- R7: In the debounce register (address 6), bit 0 selects the tick source (0 = `slow_tick`, 1 = `fast_tick`). Bits [6:4] hold an exponent n; the other bits read as 0. A sample is taken on every 2^n-th pulse of the selected source, counted from the last write of this register. Pulses of the other source have no effect.
- R8: A sample is taken at the end of the cycle in which the qualifying tick is high. The resulting pending bit becomes visible one clock cycle later. A pin level must be held for three cycles before that tick to be captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_in | input | NPINS | Asynchronous pin levels |
| slow_tick | input | 1 | One-cycle pulse from the low-frequency source |
| fast_tick | input | 1 | One-cycle pulse from the high-frequency source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from `reg_addr` |
| irq_out | output | 1 | Bank interrupt request |

## Verification
Some properties are checked on every cycle. The sample strobe must come exactly 2^n selected ticks after the previous strobe or restart. The sampled values must stay frozen between strobes. Detections may appear only in the cycle after a sample. Every detection must leave its pending bit set, even against a same-cycle clear. No pending bit may rise without a detection. Other behaviours only the bench scenarios can show. These are the field placement and code meaning of each trigger mode, level re-assertion after an acknowledge, the enable gating of the interrupt line, the exact latency, and the division count against the ignored tick source.

// File: rtl/gib_pkg.sv
`timescale 1ns/1ps
package gib_pkg;
  localparam int unsigned REG_AW        = 3;
  localparam int unsigned FIELD_W       = 4;
  localparam int unsigned PINS_PER_WORD = 8;

  localparam logic [REG_AW-1:0] ADDR_ENABLE = 3'd4;
  localparam logic [REG_AW-1:0] ADDR_STATUS = 3'd5;
  localparam logic [REG_AW-1:0] ADDR_DEBNC  = 3'd6;

  localparam logic [FIELD_W-1:0] TRIG_RISE = 4'd0;
  localparam logic [FIELD_W-1:0] TRIG_FALL = 4'd1;
  localparam logic [FIELD_W-1:0] TRIG_HIGH = 4'd2;
  localparam logic [FIELD_W-1:0] TRIG_LOW  = 4'd3;
  localparam logic [FIELD_W-1:0] TRIG_BOTH = 4'd4;
endpackage

// File: rtl/gib_prescaler.sv
`timescale 1ns/1ps
module gib_prescaler #(
  parameter int unsigned EXP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_tick,
  input  logic             fast_tick,
  input  logic             src_fast,
  input  logic [EXP_W-1:0] exp_n,
  input  logic             restart,
  output logic             sample_en
);
  localparam int unsigned CNT_W = 1 << EXP_W;

  logic             tick_sel;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] div_mask;

  assign tick_sel  = src_fast ? fast_tick : slow_tick;
  assign div_mask  = (CNT_W'(1) << exp_n) - CNT_W'(1);
  assign sample_en = tick_sel && ((cnt_q & div_mask) == div_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (tick_sel) cnt_q <= cnt_q + CNT_W'(1);
  end

  // Independent count of selected ticks since the last strobe or restart
  logic [CNT_W:0] chk_ticks;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    chk_ticks <= '0;
    else if (restart || sample_en) chk_ticks <= '0;
    else if (tick_sel)             chk_ticks <= chk_ticks + 1'b1;
  end

  a_r7_strobe_period: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !restart) |-> ((chk_ticks + 1'b1) == ((CNT_W+1)'(1) << exp_n)));
endmodule

// File: rtl/gib_sampler.sv
`timescale 1ns/1ps
module gib_sampler #(
  parameter int unsigned NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pins_in,
  input  logic             sample_en,
  output logic [NPINS-1:0] cur,
  output logic [NPINS-1:0] prv,
  output logic             upd
);
  logic [NPINS-1:0] sync1_q, sync2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      cur     <= '0;
      prv     <= '0;
      upd     <= 1'b0;
    end else begin
      sync1_q <= pins_in;
      sync2_q <= sync1_q;
      upd     <= sample_en;
      if (sample_en) begin
        cur <= sync2_q;
        prv <= cur;
      end
    end
  end

  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_en) |-> $stable(cur));
endmodule

// File: rtl/gib_detect.sv
`timescale 1ns/1ps
module gib_detect import gib_pkg::*; #(
  parameter int unsigned NPINS = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [FIELD_W*NPINS-1:0] mode_flat,
  input  logic [NPINS-1:0]         cur,
  input  logic [NPINS-1:0]         prv,
  input  logic                     upd,
  output logic [NPINS-1:0]         hit
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [FIELD_W-1:0] md;
    logic               h;
    assign md = mode_flat[p*FIELD_W +: FIELD_W];
    always_comb begin
      h = 1'b0;
      if (upd) begin
        case (md)
          TRIG_RISE: h = cur[p] & ~prv[p];
          TRIG_FALL: h = ~cur[p] & prv[p];
          TRIG_HIGH: h = cur[p];
          TRIG_LOW:  h = ~cur[p];
          TRIG_BOTH: h = cur[p] ^ prv[p];
          default:   h = 1'b0;
        endcase
      end
    end
    assign hit[p] = h;
  end

  a_r3_hit_only_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |-> upd);
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank import gib_pkg::*; #(
  parameter int unsigned NPINS = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned EXP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pins_in,
  input  logic              slow_tick,
  input  logic              fast_tick,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq_out
);
  localparam int unsigned NCFG = (NPINS + PINS_PER_WORD - 1) / PINS_PER_WORD;

  logic [NCFG-1:0][DW-1:0]   cfg_q;
  logic [NPINS-1:0]          en_q, stat_q, hit, cur, prv, clr_mask;
  logic                      upd, sample_en;
  logic                      deb_src_q;
  logic [EXP_W-1:0]          deb_exp_q;
  logic                      wr_en, wr_stat, wr_deb;
  logic [FIELD_W*NPINS-1:0]  mode_flat;

  assign wr_en   = reg_we && (reg_addr == ADDR_ENABLE);
  assign wr_stat = reg_we && (reg_addr == ADDR_STATUS);
  assign wr_deb  = reg_we && (reg_addr == ADDR_DEBNC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      en_q      <= '0;
      deb_src_q <= 1'b0;
      deb_exp_q <= '0;
    end else begin
      for (int w = 0; w < NCFG; w++)
        if (reg_we && (reg_addr == REG_AW'(w))) cfg_q[w] <= reg_wdata;
      if (wr_en) en_q <= reg_wdata[NPINS-1:0];
      if (wr_deb) begin
        deb_src_q <= reg_wdata[0];
        deb_exp_q <= reg_wdata[4 +: EXP_W];
      end
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_mode
    assign mode_flat[p*FIELD_W +: FIELD_W] =
      cfg_q[p / PINS_PER_WORD][(p % PINS_PER_WORD)*FIELD_W +: FIELD_W];
  end

  assign clr_mask = wr_stat ? reg_wdata[NPINS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | hit;
  end

  assign irq_out = |(stat_q & en_q);

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < NCFG; w++)
      if (reg_addr == REG_AW'(w)) reg_rdata = cfg_q[w];
    if (reg_addr == ADDR_ENABLE) reg_rdata = DW'(en_q);
    if (reg_addr == ADDR_STATUS) reg_rdata = DW'(stat_q);
    if (reg_addr == ADDR_DEBNC)  reg_rdata = DW'({deb_exp_q, 3'b000, deb_src_q});
  end

  gib_prescaler #(.EXP_W(EXP_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
    .src_fast(deb_src_q), .exp_n(deb_exp_q), .restart(wr_deb), .sample_en(sample_en));

  gib_sampler #(.NPINS(NPINS)) u_samp (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .sample_en(sample_en),
    .cur(cur), .prv(prv), .upd(upd));

  gib_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .mode_flat(mode_flat), .cur(cur), .prv(prv),
    .upd(upd), .hit(hit));

  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|$past(hit)) |-> (($past(hit) & ~stat_q) == '0));

  a_r6_no_phantom_pending: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_q & ~$past(stat_q) & ~$past(hit)) == '0));
endmodule

// File: tb/gpio_irq_bank_tb.sv
`timescale 1ns/1ps
module gpio_irq_bank_tb;
  localparam int N = 32;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0]  pins = '0;
  logic          slow_tick = 1'b0, fast_tick = 1'b0, reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          irq_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [N-1:0] m_cur = '0, m_prv = '0, m_stat = '0, m_en = '0;
  logic [3:0]   m_mode [N];

  always #5 clk = ~clk;

  gpio_irq_bank u_dut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins), .slow_tick(slow_tick),
    .fast_tick(fast_tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out));

  function automatic logic trig(input logic [3:0] md, input logic c, input logic p);
    case (md)
      4'd0: return c & ~p;
      4'd1: return ~c & p;
      4'd2: return c;
      4'd3: return ~c;
      4'd4: return c ^ p;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_sample(output logic [N-1:0] h);
    for (int k = 0; k < N; k++) h[k] = trig(m_mode[k], pins[k], m_cur[k]);
    m_prv = m_cur;
    m_cur = pins;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_cfg(input int w, input logic [31:0] d);
    wr(3'(w), d);
    for (int k = 0; k < 8; k++) m_mode[w*8+k] = d[k*4 +: 4];
  endtask

  task automatic wr_en(input logic [31:0] d);
    wr(3'd4, d);
    m_en = d;
  endtask

  task automatic clr(input logic [31:0] d);
    wr(3'd5, d);
    m_stat = m_stat & ~d;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fast_sample();
    logic [N-1:0] h;
    repeat (4) @(negedge clk);
    fast_tick = 1'b1;
    @(negedge clk);
    fast_tick = 1'b0;
    model_sample(h);
    m_stat = m_stat | h;
    @(negedge clk);
  endtask

  task automatic check_state(input string req);
    logic [31:0] d;
    rd(3'd5, d);
    chk(req, d, m_stat);
    chk(req, {31'b0, irq_out}, {31'b0, |(m_stat & m_en)});
  endtask

  task automatic pulse(input bit use_fast);
    @(negedge clk);
    if (use_fast) fast_tick = 1'b1; else slow_tick = 1'b1;
    @(negedge clk);
    fast_tick = 1'b0; slow_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [N-1:0] h;
    void'($urandom(32'h5EED1234));
    for (int k = 0; k < N; k++) m_mode[k] = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk("R1 reset register", d, 32'h0);
    end
    chk("R1 reset irq", {31'b0, irq_out}, 32'h0);

    // R2: config readback
    wr_cfg(1, 32'h7654_3210);
    rd(3'd1, d);
    chk("R2 config readback", d, 32'h7654_3210);
    wr_cfg(1, 32'h0);

    // R7: debounce register layout
    wr(3'd6, 32'hFFFF_FFF7);
    rd(3'd6, d);
    chk("R7 debounce readback", d, 32'h0000_0071);
    wr(3'd6, 32'h0000_0001);

    // R8: latency, pin 3 rising
    pins[3] = 1'b1;
    reg_addr = 3'd5;
    repeat (4) @(negedge clk);
    fast_tick = 1'b1;
    @(negedge clk);
    fast_tick = 1'b0;
    #1 chk("R8 not yet pending", {31'b0, reg_rdata[3]}, 32'h0);
    model_sample(h);
    m_stat = m_stat | h;
    @(negedge clk);
    #1 chk("R8 pending after one cycle", {31'b0, reg_rdata[3]}, 32'h1);

    // R4: level-high on pin 5
    wr_cfg(0, 32'h0020_0000);
    pins[5] = 1'b1;
    fast_sample();
    check_state("R4 level sets");
    clr(32'h1 << 5);
    check_state("R4 clear while high");
    fast_sample();
    rd(3'd5, d);
    chk("R4 level re-asserts", {31'b0, d[5]}, 32'h1);
    pins[5] = 1'b0;
    fast_sample();
    clr(32'h1 << 5);
    fast_sample();
    rd(3'd5, d);
    chk("R4 clear sticks after release", {31'b0, d[5]}, 32'h0);
    check_state("R4 model");

    // R5: clear all, then set beats clear in same cycle
    clr(32'hFFFF_FFFF);
    check_state("R5 clear all");
    pins[9] = 1'b1;
    repeat (4) @(negedge clk);
    fast_tick = 1'b1;
    @(negedge clk);
    fast_tick = 1'b0;
    reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h1 << 9;
    @(negedge clk);
    reg_we = 1'b0;
    model_sample(h);
    m_stat = (m_stat & ~(32'h1 << 9)) | h;
    check_state("R5 set wins");
    rd(3'd5, d);
    chk("R5 set wins bit9", {31'b0, d[9]}, 32'h1);
    clr(32'h0);
    check_state("R5 zero write keeps bits");

    // R6: enable gating
    chk("R6 masked irq low", {31'b0, irq_out}, 32'h0);
    wr_en(32'h1 << 9);
    check_state("R6 enabled irq");
    chk("R6 irq high", {31'b0, irq_out}, 32'h1);
    wr_en(~(32'h1 << 9));
    check_state("R6 other enables");

    // R2: reserved code on pin 12
    wr_cfg(1, 32'h0009_0000);
    pins[12] = 1'b1;
    fast_sample();
    pins[12] = 1'b0;
    fast_sample();
    rd(3'd5, d);
    chk("R2 reserved code", {31'b0, d[12]}, 32'h0);

    // R3/R5/R6: random patterns
    for (int it = 0; it < 40; it++) begin
      if (it % 5 == 0) begin
        d = '0;
        for (int k = 0; k < 8; k++) d[k*4 +: 4] = 4'($urandom_range(0, 4));
        wr_cfg(int'($urandom_range(0, 3)), d);
      end
      if (it % 3 == 0) wr_en($urandom);
      pins = $urandom;
      fast_sample();
      check_state("R3 random detect");
      if (it % 4 == 1) begin
        clr($urandom);
        check_state("R5 random clear");
      end
    end

    // R7: slow source, n = 2, pin 20 rising
    pins = '0;
    fast_sample();
    wr_cfg(2, 32'h0);
    wr(3'd6, 32'h0000_0020);
    clr(32'hFFFF_FFFF);
    pins[20] = 1'b1;
    repeat (4) @(negedge clk);
    repeat (5) pulse(1'b1);
    repeat (2) @(negedge clk);
    rd(3'd5, d);
    chk("R7 other source ignored", {31'b0, d[20]}, 32'h0);
    repeat (3) pulse(1'b0);
    repeat (2) @(negedge clk);
    rd(3'd5, d);
    chk("R7 three ticks no sample", {31'b0, d[20]}, 32'h0);
    pulse(1'b0);
    @(negedge clk);
    rd(3'd5, d);
    chk("R7 fourth tick samples", {31'b0, d[20]}, 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule